// File: doc/BRIEF.md
# Dual-Stream Instruction Prefetch Buffers

This block sits between an instruction memory and a decoder. It holds four line buffers, each one 32-byte line, and fills them one request at a time, always asking memory for a whole aligned line. Lines are kept as a ring in fetch order. The decoder sees a window of 16 bytes that starts at the current fetch pointer. Each cycle the decoder reports how many of those bytes it used, and the pointer moves on by that amount. When the pointer walks off the end of the oldest line, that buffer is released for reuse.

The branch predictor can report a predicted-taken branch by giving a target address. The unit then drops the sequential lines it has fetched ahead. It fills the next free buffer in the ring with the line that holds the target, points the window at the target byte, and continues fetching in order from there. A misprediction input discards everything, both stored and in flight, and restarts fetch at the corrected address from buffer zero.

An epoch number travels with every request and comes back with its response. Both kinds of redirection advance the epoch, so late replies to abandoned requests are recognised and thrown away.

Top module: `pf_dual_stream`

## Requirements
- R1: At most four lines are held at once. While four are held and none is released, `req_valid` stays low. Releasing the oldest line lets the next sequential request go out.
- R2: Only one line request is outstanding. After a request is accepted, `req_valid` stays low until its matching response arrives or a redirection occurs.
- R3: `req_addr` always has its low five bits zero. Between redirections, each accepted request asks for the line 32 bytes above the previous accepted one.
- R4: When `win_valid` is high, byte k of `win_bytes` (bits 8k+7..8k, k = 0..15) equals the memory byte at `win_addr + k`. This also holds when the window crosses into the following line.
- R5: `win_valid` is low while any of the 16 window bytes lies in a line that has not yet arrived.
- R6: When `win_valid` is high, `dec_consume` (0..16) advances `win_addr` by that amount on the next cycle. When `win_valid` is low, `dec_consume` is ignored and `win_addr` holds.
- R7: A predicted-taken redirect (`redir_valid`) sets `win_addr` to `redir_addr` on the next cycle with `win_valid` low. The next request asks for the 32-byte line holding the target, in the ring slot after the last one requested, and the window later shows the target bytes.
- R8: A misprediction flush (`flush_valid`) sets `win_addr` to `flush_addr` with `win_valid` low. Requests restart at the line holding `flush_addr` with slots numbered from 0. When both are raised in the same cycle, the flush wins.
- R9: Every flush or redirect adds one to `req_epoch` (modulo 2^EPOCH_W). A response whose epoch or slot does not match the pending request is ignored.
- R10: After reset `win_valid` is low, `win_addr` is `RESET_ADDR`, and the first request asks for the line holding `RESET_ADDR` in slot 0 with epoch 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | output | 1 | Line request pending |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Aligned line address requested |
| req_slot | output | log2(NUM_BUF) | Buffer slot the line will fill |
| req_epoch | output | EPOCH_W | Epoch tag of the request |
| rsp_valid | input | 1 | Line response present |
| rsp_slot | input | log2(NUM_BUF) | Slot tag returned with the line |
| rsp_epoch | input | EPOCH_W | Epoch tag returned with the line |
| rsp_data | input | 8*LINE_BYTES | Line data, byte k at bits 8k+7..8k |
| win_valid | output | 1 | Window bytes are all present |
| win_addr | output | ADDR_W | Current fetch pointer |
| win_bytes | output | 8*WIN_BYTES | Bytes from the fetch pointer onward |
| dec_consume | input | log2(WIN_BYTES+1) | Bytes used by the decoder this cycle |
| redir_valid | input | 1 | Predicted-taken branch |
| redir_addr | input | ADDR_W | Predicted target address |
| flush_valid | input | 1 | Misprediction flush |
| flush_addr | input | ADDR_W | Corrected restart address |

## Verification
The window is tested at several fetch pointers:
- at line start, mid-line, and exactly at a line boundary, which shows whether the shift and slot choice are right;
- with the pointer 20 bytes into a line, where the second line arrives well after the first, which shows that a spanning window waits for both lines.

Fill-order tests:
- Leaving the decoder idle fills all four buffers, and freeing one line lets exactly one more request go out. Together these show the full-ring stall and its release.
- A redirect, a flush issued while a request is in flight, and a flush raised together with a redirect show three things: slot choice after each kind of redirection, that a late reply from the old epoch is dropped, and the priority between the two inputs.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
// Shared types for the prefetch buffer unit.
package pf_pkg;
    // Per-cycle action on the fetch pointer, highest priority first in decode.
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_REDIR = 2'd2,
        CMD_FLUSH = 2'd3
    } pf_cmd_e;
endpackage

// File: rtl/pf_ring_ctrl.sv
`timescale 1ns/1ps
// Ring bookkeeping for the line buffers: oldest slot (head), next slot to
// allocate (tail) and number of allocated slots.
// Assumes NUM_BUF is a power of two so the indices wrap naturally.
module pf_ring_ctrl #(
    parameter int unsigned NUM_BUF = 4,
    parameter int unsigned IDX_W   = $clog2(NUM_BUF),
    parameter int unsigned CNT_W   = $clog2(NUM_BUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             rebase,
    input  logic             alloc_en,
    input  logic             rel_en,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] head_nx,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BUF);

    assign head_nx = head + IDX_W'(1);

    // Advance head, tail and occupancy; restart clears to slot 0, rebase keeps tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (restart) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (rebase) begin
            head <= tail;
            cnt  <= '0;
        end else begin
            if (alloc_en) tail <= tail + IDX_W'(1);
            if (rel_en)   head <= head + IDX_W'(1);
            cnt <= cnt + CNT_W'(alloc_en) - CNT_W'(rel_en);
        end
    end

    // R1
    ring_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (cnt < FULL));

    // R1
    ring_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> (cnt != '0));
endmodule

// File: rtl/pf_line_store.sv
`timescale 1ns/1ps
// Storage for the line buffers plus one "line present" flag per slot.
// Assumes a slot is written at most once between releases; data has no reset.
module pf_line_store #(
    parameter int unsigned NUM_BUF   = 4,
    parameter int unsigned LINE_BITS = 256,
    parameter int unsigned IDX_W     = $clog2(NUM_BUF)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr_all,
    input  logic                                rel_en,
    input  logic [IDX_W-1:0]                    rel_idx,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [LINE_BITS-1:0]                wr_data,
    output logic [NUM_BUF-1:0][LINE_BITS-1:0]   lines,
    output logic [NUM_BUF-1:0]                  arrived
);
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
        // Track whether slot i holds the line it was allocated for.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      arrived[i] <= 1'b0;
            else if (clr_all)                                arrived[i] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(i))           arrived[i] <= 1'b1;
            else if (rel_en && rel_idx == IDX_W'(i))         arrived[i] <= 1'b0;
        end

        // Capture line data for slot i.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) lines[i] <= wr_data;
        end
    end

    // R9
    fill_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !arrived[wr_idx]);
endmodule

// File: rtl/pf_window.sv
`timescale 1ns/1ps
// Byte window extraction: the WIN_BYTES bytes starting at byte offset `off`
// of the concatenation {line_hi, line_lo}. Assumes WIN_BYTES <= LINE_BYTES.
module pf_window #(
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned WIN_BYTES  = 16,
    parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic [8*LINE_BYTES-1:0] line_lo,
    input  logic [8*LINE_BYTES-1:0] line_hi,
    input  logic [OFF_W-1:0]        off,
    output logic [8*WIN_BYTES-1:0]  win
);
    logic [16*LINE_BYTES-1:0] pair;
    logic [16*LINE_BYTES-1:0] shifted;

    // Shift the two-line pair down to the requested byte offset.
    always_comb begin
        pair    = {line_hi, line_lo};
        shifted = pair >> {off, 3'b000};
        win     = shifted[8*WIN_BYTES-1:0];
    end
endmodule

// File: rtl/pf_dual_stream.sv
`timescale 1ns/1ps
// Instruction prefetch unit with a ring of line buffers.
// Issues one aligned line request at a time, tags it with slot and epoch,
// and exposes a byte window at the fetch pointer to the decoder. A predicted
// taken branch re-bases the ring at the next free slot; a flush restarts it at
// slot 0. Both bump the epoch so stale responses are dropped.
// Assumes: NUM_BUF a power of two, WIN_BYTES <= LINE_BYTES, dec_consume <= WIN_BYTES.
module pf_dual_stream
    import pf_pkg::*;
#(
    parameter int unsigned    ADDR_W     = 32,
    parameter int unsigned    LINE_BYTES = 32,
    parameter int unsigned    NUM_BUF    = 4,
    parameter int unsigned    WIN_BYTES  = 16,
    parameter int unsigned    EPOCH_W    = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(256)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          req_valid,
    input  logic                          req_ready,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [$clog2(NUM_BUF)-1:0]    req_slot,
    output logic [EPOCH_W-1:0]            req_epoch,
    input  logic                          rsp_valid,
    input  logic [$clog2(NUM_BUF)-1:0]    rsp_slot,
    input  logic [EPOCH_W-1:0]            rsp_epoch,
    input  logic [8*LINE_BYTES-1:0]       rsp_data,
    output logic                          win_valid,
    output logic [ADDR_W-1:0]             win_addr,
    output logic [8*WIN_BYTES-1:0]        win_bytes,
    input  logic [$clog2(WIN_BYTES+1)-1:0] dec_consume,
    input  logic                          redir_valid,
    input  logic [ADDR_W-1:0]             redir_addr,
    input  logic                          flush_valid,
    input  logic [ADDR_W-1:0]             flush_addr
);
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W     = $clog2(NUM_BUF);
    localparam int unsigned CNT_W     = $clog2(NUM_BUF + 1);
    localparam int unsigned LINE_BITS = 8 * LINE_BYTES;
    localparam logic [OFF_W:0]    WIN_SPAN  = (OFF_W+1)'(WIN_BYTES);
    localparam logic [OFF_W:0]    LINE_SPAN = (OFF_W+1)'(LINE_BYTES);
    localparam logic [CNT_W-1:0]  FULL      = CNT_W'(NUM_BUF);
    localparam logic [CNT_W-1:0]  TWO       = CNT_W'(2);
    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

    function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    logic [ADDR_W-1:0]  rd_ptr;
    logic [ADDR_W-1:0]  fetch_line;
    logic               busy;
    logic [IDX_W-1:0]   pend_idx;
    logic [EPOCH_W-1:0] epoch;

    logic [IDX_W-1:0]   head, head_nx, tail;
    logic [CNT_W-1:0]   cnt;
    logic [NUM_BUF-1:0][LINE_BITS-1:0] lines;
    logic [NUM_BUF-1:0] arrived;

    pf_cmd_e            cmd;
    logic [OFF_W-1:0]   off;
    logic [OFF_W:0]     step_sum;
    logic               spans;
    logic               hs;
    logic               rsp_ok;
    logic               rel_en;
    logic               redirecting;

    assign off         = rd_ptr[OFF_W-1:0];
    assign spans       = ({1'b0, off} + WIN_SPAN) > LINE_SPAN;
    assign step_sum    = {1'b0, off} + (OFF_W+1)'(dec_consume);
    assign redirecting = flush_valid || redir_valid;

    // Window is usable only when every byte it covers has arrived.
    always_comb begin
        win_valid = (cnt != '0) && arrived[head];
        if (spans) win_valid = win_valid && (cnt >= TWO) && arrived[head_nx];
    end

    // Pick this cycle's pointer action: flush over redirect over decoder step.
    always_comb begin
        if (flush_valid)                          cmd = CMD_FLUSH;
        else if (redir_valid)                     cmd = CMD_REDIR;
        else if (win_valid && dec_consume != '0)  cmd = CMD_STEP;
        else                                      cmd = CMD_NONE;
    end

    assign rel_en    = (cmd == CMD_STEP) && step_sum[OFF_W];
    assign req_valid = !busy && (cnt < FULL) && !redirecting;
    assign req_addr  = fetch_line;
    assign req_slot  = tail;
    assign req_epoch = epoch;
    assign hs        = req_valid && req_ready;
    assign rsp_ok    = rsp_valid && busy && !redirecting &&
                       (rsp_epoch == epoch) && (rsp_slot == pend_idx);
    assign win_addr  = rd_ptr;

    pf_ring_ctrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cmd == CMD_FLUSH),
        .rebase   (cmd == CMD_REDIR),
        .alloc_en (hs),
        .rel_en   (rel_en),
        .head     (head),
        .head_nx  (head_nx),
        .tail     (tail),
        .cnt      (cnt)
    );

    pf_line_store #(.NUM_BUF(NUM_BUF), .LINE_BITS(LINE_BITS), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (redirecting),
        .rel_en   (rel_en),
        .rel_idx  (head),
        .wr_en    (rsp_ok),
        .wr_idx   (pend_idx),
        .wr_data  (rsp_data),
        .lines    (lines),
        .arrived  (arrived)
    );

    pf_window #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES), .OFF_W(OFF_W)) u_win (
        .line_lo  (lines[head]),
        .line_hi  (lines[head_nx]),
        .off      (off),
        .win      (win_bytes)
    );

    // Fetch pointer, next line address, request tracking and epoch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr     <= RESET_ADDR;
            fetch_line <= line_of(RESET_ADDR);
            busy       <= 1'b0;
            pend_idx   <= '0;
            epoch      <= '0;
        end else begin
            unique case (cmd)
                CMD_FLUSH, CMD_REDIR: begin
                    rd_ptr     <= (cmd == CMD_FLUSH) ? flush_addr : redir_addr;
                    fetch_line <= line_of((cmd == CMD_FLUSH) ? flush_addr : redir_addr);
                    busy       <= 1'b0;
                    epoch      <= epoch + EPOCH_W'(1);
                end
                default: begin
                    if (cmd == CMD_STEP) rd_ptr <= rd_ptr + ADDR_W'(dec_consume);
                    if (hs) begin
                        busy       <= 1'b1;
                        pend_idx   <= tail;
                        fetch_line <= fetch_line + LINE_STEP;
                    end else if (rsp_ok) begin
                        busy <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Checker state: last accepted request address since the last redirection.
    logic              chk_armed;
    logic [ADDR_W-1:0] chk_last;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_armed <= 1'b0;
            chk_last  <= '0;
        end else if (redirecting) begin
            chk_armed <= 1'b0;
        end else if (hs) begin
            chk_armed <= 1'b1;
            chk_last  <= req_addr;
        end
    end

    // R2
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> !req_valid);

    // R3
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[OFF_W-1:0] == '0));

    // R3
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && chk_armed) |-> (req_addr == chk_last + LINE_STEP));

    // R6
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid && !flush_valid && !redir_valid) |=> $stable(win_addr));

    // R7
    redir_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !flush_valid) |=> (win_addr == $past(redir_addr)) && !win_valid);

    // R8
    flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (win_addr == $past(flush_addr)) && !win_valid);

    // R9
    epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid || redir_valid) |=> (req_epoch == $past(req_epoch) + EPOCH_W'(1)));
endmodule

// File: tb/sim_pf_dual_stream.sv
`timescale 1ns/1ps
// Directed bench for pf_dual_stream with a fixed-latency line memory model.
module sim_pf_dual_stream;
    localparam int LAT = 4;
    localparam logic [31:0] RST_A = 32'h0000_0100;

    logic         clk, rst_n;
    logic         req_valid, req_ready;
    logic [31:0]  req_addr;
    logic [1:0]   req_slot;
    logic [2:0]   req_epoch;
    logic         rsp_valid;
    logic [1:0]   rsp_slot;
    logic [2:0]   rsp_epoch;
    logic [255:0] rsp_data;
    logic         win_valid;
    logic [31:0]  win_addr;
    logic [127:0] win_bytes;
    logic [4:0]   dec_consume;
    logic         redir_valid, flush_valid;
    logic [31:0]  redir_addr, flush_addr;

    int n_chk = 0;
    int n_fail = 0;
    int hs_cnt = 0;
    logic [1:0]  last_slot;
    logic [31:0] last_addr;

    initial clk = 1'b0;
    always #10 clk = ~clk;

    pf_dual_stream #(.RESET_ADDR(RST_A)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_slot(req_slot), .req_epoch(req_epoch),
        .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_epoch(rsp_epoch), .rsp_data(rsp_data),
        .win_valid(win_valid), .win_addr(win_addr), .win_bytes(win_bytes),
        .dec_consume(dec_consume),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .flush_valid(flush_valid), .flush_addr(flush_addr)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ {a[10:8], a[14:10]};
    endfunction

    function automatic logic [255:0] line_data(input logic [31:0] base);
        logic [255:0] d;
        for (int k = 0; k < 32; k++) d[8*k +: 8] = mem_byte(base + 32'(k));
        return d;
    endfunction

    function automatic logic [127:0] exp_win(input logic [31:0] a);
        logic [127:0] w;
        for (int k = 0; k < 16; k++) w[8*k +: 8] = mem_byte(a + 32'(k));
        return w;
    endfunction

    // Memory model: always ready, answers each request LAT cycles later.
    logic        pv [LAT];
    logic [31:0] pa [LAT];
    logic [1:0]  ps [LAT];
    logic [2:0]  pe [LAT];
    assign req_ready = 1'b1;
    assign rsp_valid = pv[LAT-1];
    assign rsp_slot  = ps[LAT-1];
    assign rsp_epoch = pe[LAT-1];
    assign rsp_data  = line_data(pa[LAT-1]);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
        end else begin
            pv[0] <= req_valid && req_ready;
            pa[0] <= req_addr;
            ps[0] <= req_slot;
            pe[0] <= req_epoch;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pa[i] <= pa[i-1];
                ps[i] <= ps[i-1];
                pe[i] <= pe[i-1];
            end
            if (req_valid && req_ready) begin
                hs_cnt    <= hs_cnt + 1;
                last_slot <= req_slot;
                last_addr <= req_addr;
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_consume(input int n);
        dec_consume = 5'(n);
        @(negedge clk);
        dec_consume = '0;
    endtask

    task automatic do_flush(input logic [31:0] a);
        flush_valid = 1'b1;
        flush_addr  = a;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    task automatic wait_valid(input string tag);
        int i = 0;
        while (!win_valid && i < 400) begin
            @(negedge clk);
            i++;
        end
        chk(tag, 128'(win_valid), 128'(1));
    endtask

    task automatic wait_hs(input int target);
        int i = 0;
        while (hs_cnt < target && i < 400) begin
            @(negedge clk);
            i++;
        end
    endtask

    // R10: state straight after reset.
    task automatic t_reset();
        chk("R10 win_valid after reset", 128'(win_valid), 128'(0));
        chk("R10 win_addr after reset", 128'(win_addr), 128'(RST_A));
        chk("R10 first req_addr", 128'(req_addr), 128'(32'h100));
        chk("R10 first req_slot", 128'(req_slot), 128'(0));
        chk("R10 first req_epoch", 128'(req_epoch), 128'(0));
    endtask

    // R4, R6: windows at line start, mid-line, spanning and on a boundary.
    task automatic t_sequential();
        wait_valid("R4 window valid at start");
        chk("R4 bytes at 0x100", win_bytes, exp_win(32'h100));
        pulse_consume(12);
        chk("R6 pointer after 12", 128'(win_addr), 128'(32'h10C));
        wait_valid("R4 valid at 0x10C");
        chk("R4 bytes at 0x10C", win_bytes, exp_win(32'h10C));
        pulse_consume(16);
        chk("R6 pointer after 16", 128'(win_addr), 128'(32'h11C));
        wait_valid("R4 valid spanning");
        chk("R4 bytes spanning 0x11C", win_bytes, exp_win(32'h11C));
        pulse_consume(4);
        wait_valid("R4 valid at boundary");
        chk("R6 pointer at boundary", 128'(win_addr), 128'(32'h120));
        chk("R4 bytes at 0x120", win_bytes, exp_win(32'h120));
        pulse_consume(0);
        chk("R6 zero consume holds", 128'(win_addr), 128'(32'h120));
    endtask

    // R1, R3, R8: idle decoder fills the ring, then one release frees one slot.
    task automatic t_full_stall();
        int base;
        do_flush(32'h2000);
        base = hs_cnt;
        repeat (60) @(negedge clk);
        chk("R1 four requests when idle", 128'(hs_cnt - base), 128'(4));
        chk("R1 req_valid low when full", 128'(req_valid), 128'(0));
        chk("R8 slots from 0 after flush", 128'(last_slot), 128'(3));
        wait_valid("R4 valid at 0x2000");
        pulse_consume(16);
        pulse_consume(16);
        repeat (3) @(negedge clk);
        chk("R1 one request after release", 128'(hs_cnt - base), 128'(5));
        chk("R3 next sequential line", 128'(last_addr), 128'(32'h2080));
        chk("R1 freed slot reused", 128'(last_slot), 128'(0));
    endtask

    // R5, R6, R8: window 20 bytes into a line waits for the second line.
    task automatic t_span();
        int base;
        do_flush(32'h3014);
        base = hs_cnt;
        chk("R8 win_addr after flush", 128'(win_addr), 128'(32'h3014));
        chk("R8 win_valid low after flush", 128'(win_valid), 128'(0));
        pulse_consume(8);
        chk("R6 consume ignored while invalid", 128'(win_addr), 128'(32'h3014));
        wait_hs(base + 2);
        chk("R5 invalid with second line missing", 128'(win_valid), 128'(0));
        wait_valid("R5 valid once both lines present");
        chk("R4 bytes at 0x3014", win_bytes, exp_win(32'h3014));
    endtask

    // R7, R9, R3: predicted-taken redirect to a target mid-line.
    task automatic t_redirect();
        logic [1:0] exp_slot;
        logic [2:0] ep;
        int base;
        exp_slot = last_slot + 2'd1;
        ep = req_epoch;
        redir_valid = 1'b1;
        redir_addr  = 32'h4046;
        @(negedge clk);
        redir_valid = 1'b0;
        chk("R7 win_addr at target", 128'(win_addr), 128'(32'h4046));
        chk("R7 win_valid low after redirect", 128'(win_valid), 128'(0));
        chk("R7 request for target line", 128'(req_addr), 128'(32'h4040));
        chk("R7 target in next free slot", 128'(req_slot), 128'(exp_slot));
        chk("R9 epoch advanced", 128'(req_epoch), 128'(ep + 3'd1));
        base = hs_cnt;
        wait_valid("R7 target window valid");
        chk("R7 bytes at target", win_bytes, exp_win(32'h4046));
        wait_hs(base + 2);
        chk("R3 sequential after target", 128'(last_addr), 128'(32'h4060));
    endtask

    // R9: a flush while a request is in flight drops the late reply.
    task automatic t_flush_stale();
        int b;
        do_flush(32'h5100);
        b = hs_cnt;
        wait_hs(b + 1);
        do_flush(32'h5008);
        chk("R8 slot 0 after second flush", 128'(req_slot), 128'(0));
        wait_valid("R9 valid after stale drop");
        chk("R9 stale line not used", win_bytes, exp_win(32'h5008));
    endtask

    // R8: flush and redirect in the same cycle, flush wins.
    task automatic t_priority();
        flush_valid = 1'b1;
        flush_addr  = 32'h6000;
        redir_valid = 1'b1;
        redir_addr  = 32'h7000;
        @(negedge clk);
        flush_valid = 1'b0;
        redir_valid = 1'b0;
        chk("R8 flush beats redirect addr", 128'(win_addr), 128'(32'h6000));
        chk("R8 flush beats redirect req", 128'(req_addr), 128'(32'h6000));
        chk("R8 flush beats redirect slot", 128'(req_slot), 128'(0));
        wait_valid("R8 valid after priority");
        chk("R4 bytes at 0x6000", win_bytes, exp_win(32'h6000));
    endtask

    initial begin
        rst_n       = 1'b0;
        dec_consume = '0;
        redir_valid = 1'b0;
        flush_valid = 1'b0;
        redir_addr  = '0;
        flush_addr  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_sequential();
        t_full_stall();
        t_span();
        t_redirect();
        t_flush_stale();
        t_priority();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule